// File: doc/BRIEF.md
# Dual-Channel Toggle / PWM Timer

This block is a 16-bit timer made of two 8-bit counter halves, each with its own 8-bit prescaler. A 2-bit mode input selects one of four configurations. The configurations are two independent toggle timers, two 8-bit PWM channels, one 16-bit toggle timer/counter, or one 16-bit toggle timer whose low byte also drives a PWM output. Each half drives one waveform pin and raises its own one-cycle interrupt request.

Counting advances on the `tick` qualifier through the prescalers. The upper unit in split mode, and the whole 16-bit counter in wide mode, may instead count cycles in which `extEvent` is high. PWM compare values are double-buffered. A new compare value is held in a shadow register and is applied only at the next period boundary, so a waveform never changes shape partway through a period. Pin multiplexing and register access belong to the surrounding logic.

Top module: `dual_wave_timer`

## Requirements
- R1: After reset both counters and both prescalers are zero, both PWM shadows are zero, and `outLo`, `outHi`, `irqLo` and `irqHi` are all low.
- R2: A prescaler with setting P counts `tick` cycles and produces one counting step for its half every P+1 ticks. While `tick` is low, no prescaled half advances and no output or interrupt changes.
- R3: Mode 0 (`mode`=0, split toggle) treats each half as its own timer. On a step where its count equals its match value, the count reloads to 0, its output inverts and its interrupt pulses for one cycle; on any other step the count increments. The result is one toggle every (P+1)*(M+1) ticks.
- R4: In mode 0 with `extSel`=1, the upper half takes one step per clock cycle in which `extEvent` is high, and its prescaler setting and `tick` have no effect on it.
- R5: Mode 1 (`mode`=1, dual PWM) runs each half as a free 8-bit counter with period 256 steps. Its output is high exactly while the count is below its active compare value, so a compare of 0 holds the output low. Its interrupt pulses on each step from 255 to 0.
- R6: A compare input is copied into its shadow only on a step that starts a new PWM period: the low-byte wrap from 255 to 0, or in mode 3 also the 16-bit reload. A compare change made mid-period has no effect on the current period.
- R7: Mode 2 (`mode`=2, wide toggle) forms the count {hi,lo}. It steps from the low prescaler, or from `extEvent` when `extSel`=1. On a step where the count equals {`matchHi`,`matchLo`} the count reloads to 0, `outHi` inverts and `irqHi` pulses. On every step where the low byte equals `matchLo`, `outLo` inverts and `irqLo` pulses.
- R8: Mode 3 (`mode`=3, wide toggle with PWM) steps the 16-bit count from the low prescaler only, ignoring `extSel`, with the `outHi`/`irqHi` behaviour of R7. `outLo` is the PWM of the low byte against the low shadow, and `irqLo` pulses on each low-byte period boundary of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count qualifier fed to both prescalers |
| extEvent | input | 1 | External event; one step per high cycle when selected |
| extSel | input | 1 | Selects extEvent as step source (mode 0 upper half, mode 2) |
| mode | input | 2 | 0 split toggle, 1 dual PWM, 2 wide toggle, 3 wide toggle + PWM |
| preLo | input | 8 | Low prescaler setting (divide by value+1) |
| preHi | input | 8 | High prescaler setting (divide by value+1) |
| matchLo | input | 8 | Low-half match / reload value |
| matchHi | input | 8 | High-half match / reload value |
| cmpLo | input | 8 | Low PWM compare (buffered) |
| cmpHi | input | 8 | High PWM compare (buffered) |
| outLo | output | 1 | Low-half waveform |
| outHi | output | 1 | High-half waveform |
| irqLo | output | 1 | Low-half interrupt pulse |
| irqHi | output | 1 | High-half interrupt pulse |

## Verification
The hardest situation to reach from the ports is a compare value written partway through a PWM period, because the shadow is invisible until the next boundary. The bench starts from reset with a known count phase. It changes `cmpLo` at a computed cycle inside the second period and counts high cycles in each 256-step window separately, which shows the old value holding until the wrap. The 16-bit reload in mode 3 is reached by running past a non-power-of-two match value, so that a period boundary happens before the low byte would naturally wrap.

// File: rtl/dual_wave_pkg.sv
package dual_wave_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT    = 2'd0,
    MODE_PWM      = 2'd1,
    MODE_WIDE     = 2'd2,
    MODE_WIDE_PWM = 2'd3
  } wave_mode_e;

  // Strobes from control to datapath, one set per half.
  typedef struct packed {
    logic incLo;
    logic clrLo;
    logic incHi;
    logic clrHi;
    logic togLo;
    logic togHi;
    logic shLo;
    logic shHi;
    logic irqLo;
    logic irqHi;
    logic pwmLo;
    logic pwmHi;
  } wave_strobe_t;

endpackage

// File: rtl/dual_wave_ctrl.sv
module dual_wave_ctrl
  import dual_wave_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic [1:0]        mode,
  input  logic              extSel,
  input  logic              extEvent,
  input  logic              preWrapLo,
  input  logic              preWrapHi,
  input  logic [HALF_W-1:0] cntLo,
  input  logic [HALF_W-1:0] cntHi,
  input  logic [HALF_W-1:0] matchLo,
  input  logic [HALF_W-1:0] matchHi,
  output wave_strobe_t      strb
);

  localparam logic [HALF_W-1:0] LAST = {HALF_W{1'b1}};

  wave_mode_e modeE;
  logic       stepHiSplit;
  logic       step16;
  logic       fullMatch;

  assign modeE       = wave_mode_e'(mode);
  assign stepHiSplit = extSel ? extEvent : preWrapHi;
  assign fullMatch   = ({cntHi, cntLo} == {matchHi, matchLo});
  assign step16      = (modeE == MODE_WIDE && extSel) ? extEvent : preWrapLo;

  always_comb begin
    strb = '0;
    case (modeE)
      MODE_SPLIT: begin
        if (preWrapLo) begin
          if (cntLo == matchLo) begin
            strb.clrLo = 1'b1;
            strb.togLo = 1'b1;
            strb.irqLo = 1'b1;
          end else begin
            strb.incLo = 1'b1;
          end
        end
        if (stepHiSplit) begin
          if (cntHi == matchHi) begin
            strb.clrHi = 1'b1;
            strb.togHi = 1'b1;
            strb.irqHi = 1'b1;
          end else begin
            strb.incHi = 1'b1;
          end
        end
      end
      MODE_PWM: begin
        strb.pwmLo = 1'b1;
        strb.pwmHi = 1'b1;
        if (preWrapLo) begin
          strb.incLo = 1'b1;
          if (cntLo == LAST) begin
            strb.shLo  = 1'b1;
            strb.irqLo = 1'b1;
          end
        end
        if (preWrapHi) begin
          strb.incHi = 1'b1;
          if (cntHi == LAST) begin
            strb.shHi  = 1'b1;
            strb.irqHi = 1'b1;
          end
        end
      end
      default: begin
        strb.pwmLo = (modeE == MODE_WIDE_PWM);
        if (step16) begin
          if (fullMatch) begin
            strb.clrLo = 1'b1;
            strb.clrHi = 1'b1;
            strb.togHi = 1'b1;
            strb.irqHi = 1'b1;
          end else begin
            strb.incLo = 1'b1;
            strb.incHi = (cntLo == LAST);
          end
          if (modeE == MODE_WIDE) begin
            if (cntLo == matchLo) begin
              strb.togLo = 1'b1;
              strb.irqLo = 1'b1;
            end
          end else if (fullMatch || cntLo == LAST) begin
            strb.shLo  = 1'b1;
            strb.irqLo = 1'b1;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/dual_wave_datapath.sv
module dual_wave_datapath
  import dual_wave_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [PRE_W-1:0]  preLo,
  input  logic [PRE_W-1:0]  preHi,
  input  logic [HALF_W-1:0] cmpLo,
  input  logic [HALF_W-1:0] cmpHi,
  input  wave_strobe_t      strb,
  output logic              preWrapLo,
  output logic              preWrapHi,
  output logic [HALF_W-1:0] cntLo,
  output logic [HALF_W-1:0] cntHi,
  output logic              outLo,
  output logic              outHi,
  output logic              irqLo,
  output logic              irqHi
);

  localparam int HALVES = 2;

  logic [HALVES-1:0][PRE_W-1:0]  preSet;
  logic [HALVES-1:0][HALF_W-1:0] cmpIn;
  logic [HALVES-1:0][PRE_W-1:0]  preCnt;
  logic [HALVES-1:0][HALF_W-1:0] cnt;
  logic [HALVES-1:0][HALF_W-1:0] shadow;
  logic [HALVES-1:0]             togFf, irqFf, preWrap, waveOut;
  logic [HALVES-1:0]             incV, clrV, togV, shV, irqV, pwmV;

  assign preSet = {preHi, preLo};
  assign cmpIn  = {cmpHi, cmpLo};
  assign incV   = {strb.incHi, strb.incLo};
  assign clrV   = {strb.clrHi, strb.clrLo};
  assign togV   = {strb.togHi, strb.togLo};
  assign shV    = {strb.shHi,  strb.shLo};
  assign irqV   = {strb.irqHi, strb.irqLo};
  assign pwmV   = {strb.pwmHi, strb.pwmLo};

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    assign preWrap[g] = tick && (preCnt[g] == preSet[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        preCnt[g] <= '0;
        cnt[g]    <= '0;
        shadow[g] <= '0;
        togFf[g]  <= 1'b0;
        irqFf[g]  <= 1'b0;
      end else begin
        if (tick) preCnt[g] <= preWrap[g] ? '0 : preCnt[g] + 1'b1;
        if (clrV[g])      cnt[g] <= '0;
        else if (incV[g]) cnt[g] <= cnt[g] + 1'b1;
        if (shV[g])  shadow[g] <= cmpIn[g];
        if (togV[g]) togFf[g]  <= ~togFf[g];
        irqFf[g] <= irqV[g];
      end
    end

    assign waveOut[g] = pwmV[g] ? (cnt[g] < shadow[g]) : togFf[g];

    // R3
    reload_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      clrV[g] |=> (cnt[g] == '0));
    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
      togV[g] |=> (togFf[g] != $past(togFf[g])));
    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !shV[g] |=> $stable(shadow[g]));
    // R5
    zero_cmp_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pwmV[g] && shadow[g] == '0) |-> !waveOut[g]);
    // R2
    prescale_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !tick |=> $stable(preCnt[g]));
  end

  assign preWrapLo = preWrap[0];
  assign preWrapHi = preWrap[1];
  assign cntLo     = cnt[0];
  assign cntHi     = cnt[1];
  assign outLo     = waveOut[0];
  assign outHi     = waveOut[1];
  assign irqLo     = irqFf[0];
  assign irqHi     = irqFf[1];

endmodule

// File: rtl/dual_wave_timer.sv
module dual_wave_timer
  import dual_wave_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              extEvent,
  input  logic              extSel,
  input  logic [1:0]        mode,
  input  logic [PRE_W-1:0]  preLo,
  input  logic [PRE_W-1:0]  preHi,
  input  logic [HALF_W-1:0] matchLo,
  input  logic [HALF_W-1:0] matchHi,
  input  logic [HALF_W-1:0] cmpLo,
  input  logic [HALF_W-1:0] cmpHi,
  output logic              outLo,
  output logic              outHi,
  output logic              irqLo,
  output logic              irqHi
);

  wave_strobe_t      strb;
  logic              preWrapLo, preWrapHi;
  logic [HALF_W-1:0] cntLo, cntHi;

  dual_wave_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .mode(mode), .extSel(extSel), .extEvent(extEvent),
    .preWrapLo(preWrapLo), .preWrapHi(preWrapHi),
    .cntLo(cntLo), .cntHi(cntHi),
    .matchLo(matchLo), .matchHi(matchHi),
    .strb(strb)
  );

  dual_wave_datapath #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick),
    .preLo(preLo), .preHi(preHi), .cmpLo(cmpLo), .cmpHi(cmpHi),
    .strb(strb),
    .preWrapLo(preWrapLo), .preWrapHi(preWrapHi),
    .cntLo(cntLo), .cntHi(cntHi),
    .outLo(outLo), .outHi(outHi), .irqLo(irqLo), .irqHi(irqHi)
  );

endmodule

// File: tb/dual_wave_timer_tb.sv
module dual_wave_timer_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0, extEvent = 1'b0, extSel = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] preLo = '0, preHi = '0, matchLo = '0, matchHi = '0, cmpLo = '0, cmpHi = '0;
  logic       outLo, outHi, irqLo, irqHi;

  int checks = 0;
  int failures = 0;
  int iL, iH, hA, hB, hC, bad, expL, expH;

  always #5 clk = ~clk;

  dual_wave_timer u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .extEvent(extEvent), .extSel(extSel),
    .mode(mode), .preLo(preLo), .preHi(preHi), .matchLo(matchLo), .matchHi(matchHi),
    .cmpLo(cmpLo), .cmpHi(cmpHi),
    .outLo(outLo), .outHi(outHi), .irqLo(irqLo), .irqHi(irqHi)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; tick = 1'b0; extEvent = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic checkIdle();
    chk("R1 outLo after reset", int'(outLo), 0);
    chk("R1 outHi after reset", int'(outHi), 0);
    chk("R1 irq after reset", int'(irqLo) + int'(irqHi), 0);
  endtask

  // Run n edges, counting interrupt pulses (sampled at the falling edge).
  task automatic runCount(int n);
    iL = 0; iH = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); @(negedge clk);
      iL += int'(irqLo); iH += int'(irqHi);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R3 / R2: mode 0 sweep over prescaler and match settings
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 3; m++) begin
        mode = 2'd0; extSel = 1'b0;
        preLo = 8'(p * 2); matchLo = 8'(m * 3);
        preHi = 8'(p + 1); matchHi = 8'(m * 2 + 1);
        doReset();
        checkIdle();
        tick = 1'b1;
        runCount(100);
        tick = 1'b0;
        expL = 100 / ((p * 2 + 1) * (m * 3 + 1));
        expH = 100 / ((p + 2) * (m * 2 + 2));
        chk("R3 irqLo pulses", iL, expL);
        chk("R3 outLo level", int'(outLo), expL % 2);
        chk("R3 irqHi pulses", iH, expH);
        chk("R3 outHi level", int'(outHi), expH % 2);
        runCount(10);
        chk("R2 no pulses while tick low", iL + iH, 0);
        chk("R2 outputs hold while tick low", int'(outLo) * 2 + int'(outHi),
            (expL % 2) * 2 + (expH % 2));
      end
    end

    // R4: upper half from external events, prescaler and tick ignored
    mode = 2'd0; extSel = 1'b1; preHi = 8'd7; matchHi = 8'd4; preLo = 8'd0; matchLo = 8'd0;
    doReset();
    extEvent = 1'b1;
    runCount(23);
    extEvent = 1'b0;
    chk("R4 irqHi from events", iH, 4);
    chk("R4 outHi level", int'(outHi), 0);
    chk("R4 low half idle without tick", iL + int'(outLo), 0);

    // R5 / R6: dual PWM, mid-period compare change
    mode = 2'd1; extSel = 1'b0; preLo = 8'd0; preHi = 8'd1; cmpLo = 8'd100; cmpHi = 8'd40;
    doReset();
    checkIdle();
    tick = 1'b1;
    iL = 0; iH = 0; hA = 0; hB = 0; hC = 0; bad = 0;
    for (int k = 1; k <= 1024; k++) begin
      @(posedge clk); @(negedge clk);
      iL += int'(irqLo); iH += int'(irqHi);
      if (k < 256 && outLo) bad++;
      if (k < 512 && outHi) bad++;
      if (k >= 256 && k <= 511) hA += int'(outLo);
      if (k >= 512 && k <= 767) hB += int'(outLo);
      if (k >= 512 && k <= 1023) hC += int'(outHi);
      if (k == 300) cmpLo = 8'd17;
    end
    tick = 1'b0;
    chk("R6 outputs low before first boundary", bad, 0);
    chk("R6 old compare kept after mid-period write", hA, 100);
    chk("R6 new compare after boundary", hB, 17);
    chk("R5 hi channel duty with prescale 2", hC, 80);
    chk("R5 irqLo per 256 steps", iL, 4);
    chk("R5 irqHi per 256 steps", iH, 2);

    // R5: compare 0 stays low, compare 255
    cmpLo = 8'd0; cmpHi = 8'd255; preHi = 8'd0;
    doReset();
    checkIdle();
    tick = 1'b1;
    hA = 0; hB = 0;
    for (int k = 1; k <= 600; k++) begin
      @(posedge clk); @(negedge clk);
      hA += int'(outLo);
      if (k >= 256 && k <= 511) hB += int'(outHi);
    end
    tick = 1'b0;
    chk("R5 compare 0 constant low", hA, 0);
    chk("R5 compare 255 high count", hB, 255);

    // R7: wide mode from external events
    mode = 2'd2; extSel = 1'b1; preLo = 8'd5; matchHi = 8'd1; matchLo = 8'd3;
    doReset();
    checkIdle();
    extEvent = 1'b1;
    runCount(600);
    extEvent = 1'b0;
    expL = 0;
    for (int j = 0; j < 600; j++) if ((j % 260) == 3 || (j % 260) == 259) expL++;
    chk("R7 irqLo on low-byte match (events)", iL, expL);
    chk("R7 outLo level (events)", int'(outLo), expL % 2);
    chk("R7 irqHi on 16-bit match (events)", iH, 600 / 260);
    chk("R7 outHi level (events)", int'(outHi), (600 / 260) % 2);

    // R7: wide mode from prescaler
    extSel = 1'b0; preLo = 8'd1;
    doReset();
    tick = 1'b1;
    runCount(600);
    tick = 1'b0;
    expL = 0;
    for (int j = 0; j < 300; j++) if ((j % 260) == 3 || (j % 260) == 259) expL++;
    chk("R7 irqLo on low-byte match (prescaled)", iL, expL);
    chk("R7 outLo level (prescaled)", int'(outLo), expL % 2);
    chk("R7 irqHi on 16-bit match (prescaled)", iH, 1);
    chk("R7 outHi level (prescaled)", int'(outHi), 1);

    // R8: wide toggle with low-byte PWM; extSel must be ignored
    mode = 2'd3; extSel = 1'b1; preLo = 8'd0; matchHi = 8'd2; matchLo = 8'h10; cmpLo = 8'd100;
    doReset();
    tick = 1'b1;
    iL = 0; iH = 0; hA = 0; bad = 0; hB = 0;
    for (int k = 1; k <= 1100; k++) begin
      @(posedge clk); @(negedge clk);
      iL += int'(irqLo); iH += int'(irqHi);
      if (k < 256 && outLo) bad++;
      if (k >= 256 && k <= 511) hA += int'(outLo);
      if (k == 600) hB = int'(outHi);
    end
    tick = 1'b0;
    chk("R8 PWM low before first boundary", bad, 0);
    chk("R8 low-byte PWM duty", hA, 100);
    chk("R8 irqLo on low boundaries and reload", iL, 6);
    chk("R8 irqHi on 16-bit reload", iH, 2);
    chk("R8 outHi after one reload", hB, 1);
    chk("R8 outHi after two reloads", int'(outHi), 0);

    doReset();
    checkIdle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule